// File: doc/BRIEF.md
# Ethernet Controller Reset Sequencer

This block takes an external Ethernet controller chip through a full restart. It pulls the chip's bidirectional active-low reset pin low for a fixed number of clocks and then releases it. It then waits for the chip to settle. The wait ends either when a settle timer runs out or when the chip pulls its active-low interrupt line low. After that the block walks a short built-in script of control-register accesses through a byte-wide transceiver. Each access is one Go pulse followed by a Done reply. The script first writes a few configuration registers and then reads back the six station-address bytes. Each byte that comes back is stored into a small MAC address register file.

The sequence starts by itself when the synchronous reset is released. It can be started again later with a start pulse while the block is idle. A debug strap cuts both hardware waiting periods down to a single clock. A one-cycle done pulse marks the end of each run.

Top module: `ethrst_seq`

## Requirements
- R1: While `rst` is high, the reset pin is released (not driven), and `reg_go`, `mac_we` and `seq_done` are low.
- R2: A run begins on its own in the first clock after `rst` falls. A `start` pulse seen while idle begins another run.
- R3: At the start of a run, the reset pin is driven low for exactly `HOLD_CYC` clocks and is then released to high impedance.
- R4: After the pin is released, the first `reg_go` appears `SETTLE_CYC`+2 clocks later. If `nic_irq_n` is low on the first settle clock, the first `reg_go` appears 3 clocks after release instead.
- R5: With `dbg_short` high, the pin is low for one clock and the first `reg_go` follows 3 clocks after release.
- R6: `reg_go` is high for exactly one clock. No new `reg_go` is issued until `reg_done` has been seen for the current access. A `reg_done` that arrives while no access is outstanding has no effect.
- R7: The script issues, in this order, the writes (address←data) 0x04←0x80, 0x05←0x10, 0x06←0x3C and 0x07←0x01 with `reg_rd` low. It then issues reads of addresses 0x60 through 0x65 in ascending order with `reg_rd` high, for ten accesses in all.
- R8: For the read of address 0x60+i, the byte on `reg_rdata` in the `reg_done` cycle is written with `mac_we` to `mac_addr` i. The writes go in ascending order 0 to 5, one for each read.
- R9: `seq_done` is high for one clock, exactly once per run. It appears together with the last MAC byte write.
- R10: A `start` pulse during a run is ignored: no extra accesses, no second done pulse, and no new reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when the block is idle |
| dbg_short | input | 1 | Debug strap that shortens both waiting periods to one clock |
| nic_rst_n | inout | 1 | Controller reset pin: driven low during reset, high impedance otherwise |
| nic_irq_n | input | 1 | Controller interrupt, active low, ends the settle wait early |
| reg_go | output | 1 | One-clock request for one controller register access |
| reg_addr | output | 8 | Controller register address |
| reg_wdata | output | 8 | Write value |
| reg_rd | output | 1 | High for a read, low for a write |
| reg_rdata | input | 8 | Read value returned by the transceiver |
| reg_done | input | 1 | Access completion from the transceiver |
| mac_we | output | 1 | MAC address register file write enable |
| mac_addr | output | 4 | MAC address byte index |
| mac_data | output | 8 | MAC address byte value |
| seq_done | output | 1 | One-clock end-of-run pulse |

## Verification
The bench builds the block with `HOLD_CYC`=12 and `SETTLE_CYC`=40, in place of the thousands of clocks a real chip needs. With these values the reset-low length and the release-to-first-Go gap can be counted exactly, and several full runs fit in a short simulation. `MAC_BYTES` stays at its default of 6. The full read-back path, including the ascending register-file writes, is therefore exercised at its real size. The transceiver reply delay is varied from zero to six clocks, which places Done both in the Go cycle itself and well after it.

// File: rtl/ethrst_pkg.sv
package ethrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] wdata;
  } step_t;

  localparam int unsigned INIT_STEPS  = 4;
  localparam logic [7:0]  MAC_RD_BASE = 8'h60;

  // Configuration writes come first; every later step reads one address byte.
  function automatic step_t step_at(int unsigned idx);
    step_t s;
    s = '0;
    case (idx)
      0: s = '{rd: 1'b0, addr: 8'h04, wdata: 8'h80};
      1: s = '{rd: 1'b0, addr: 8'h05, wdata: 8'h10};
      2: s = '{rd: 1'b0, addr: 8'h06, wdata: 8'h3C};
      3: s = '{rd: 1'b0, addr: 8'h07, wdata: 8'h01};
      default: begin
        s.rd   = 1'b1;
        s.addr = MAC_RD_BASE + 8'(idx - INIT_STEPS);
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ethrst_timer.sv
module ethrst_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ethrst_step_rom.sv
module ethrst_step_rom
  import ethrst_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output step_t         q
);

  step_t rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = step_at(g);
  end

  // Registered read port, one clock of latency.
  always_ff @(posedge clk) begin
    q <= rom[addr];
  end

endmodule

// File: rtl/ethrst_xfer.sv
module ethrst_xfer (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       req_rd,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       xcv_done,
  input  logic [7:0] xcv_rdata,
  output logic       go,
  output logic [7:0] addr,
  output logic [7:0] wdata,
  output logic       rd,
  output logic       cpl,
  output logic [7:0] cpl_data
);

  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      go     <= 1'b0;
      pend_q <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      rd     <= 1'b0;
    end else begin
      go <= 1'b0;
      if (req && !pend_q) begin
        go     <= 1'b1;
        pend_q <= 1'b1;
        addr   <= req_addr;
        wdata  <= req_wdata;
        rd     <= req_rd;
      end else if (pend_q && xcv_done) begin
        pend_q <= 1'b0;
      end
    end
  end

  // A Done reply only counts while an access is outstanding.
  assign cpl      = pend_q & xcv_done;
  assign cpl_data = xcv_rdata;

endmodule

// File: rtl/ethrst_seq.sv
module ethrst_seq
  import ethrst_pkg::*;
#(
  parameter int HOLD_CYC   = 1000,
  parameter int SETTLE_CYC = 5000,
  parameter int MAC_BYTES  = 6,
  parameter int MAC_AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dbg_short,
  inout  wire               nic_rst_n,
  input  logic              nic_irq_n,
  output logic              reg_go,
  output logic [7:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata,
  input  logic              reg_done,
  output logic              mac_we,
  output logic [MAC_AW-1:0] mac_addr,
  output logic [7:0]        mac_data,
  output logic              seq_done
);

  localparam int STEPS = INIT_STEPS + MAC_BYTES;
  localparam int SAW   = $clog2(STEPS);
  localparam int TMAX  = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int TW    = $clog2(TMAX + 1);

  seq_state_e       st_q;
  logic             boot_q;
  logic             hold_q;
  logic [SAW-1:0]   idx_q;
  logic [MAC_AW-1:0] mac_idx_q;
  logic [1:0]       irq_sync_q;
  logic             irq_low;
  logic             t_load;
  logic [TW-1:0]    t_val;
  logic             t_zero;
  step_t            step_q;
  logic             cpl;
  logic [7:0]       cpl_data;
  logic             go_req;
  logic             launch;

  // Open-drain style reset pin: low or released.
  assign nic_rst_n = hold_q ? 1'b0 : 1'bz;

  always_ff @(posedge clk) begin
    if (rst) irq_sync_q <= 2'b11;
    else     irq_sync_q <= {irq_sync_q[0], nic_irq_n};
  end
  assign irq_low = ~irq_sync_q[1];

  assign launch = (st_q == ST_IDLE) && (boot_q || start);
  assign t_load = launch || ((st_q == ST_HOLD) && t_zero);

  always_comb begin
    if (dbg_short)            t_val = '0;
    else if (st_q == ST_IDLE) t_val = TW'(HOLD_CYC - 1);
    else                      t_val = TW'(SETTLE_CYC - 1);
  end

  ethrst_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  ethrst_step_rom #(.DEPTH(STEPS), .AW(SAW)) u_rom (
    .clk  (clk),
    .addr (idx_q),
    .q    (step_q)
  );

  assign go_req = (st_q == ST_ISSUE);

  ethrst_xfer u_xfer (
    .clk       (clk),
    .rst       (rst),
    .req       (go_req),
    .req_rd    (step_q.rd),
    .req_addr  (step_q.addr),
    .req_wdata (step_q.wdata),
    .xcv_done  (reg_done),
    .xcv_rdata (reg_rdata),
    .go        (reg_go),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rd        (reg_rd),
    .cpl       (cpl),
    .cpl_data  (cpl_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      boot_q    <= 1'b1;
      hold_q    <= 1'b0;
      idx_q     <= '0;
      mac_idx_q <= '0;
      mac_we    <= 1'b0;
      mac_addr  <= '0;
      mac_data  <= '0;
      seq_done  <= 1'b0;
    end else begin
      mac_we   <= 1'b0;
      seq_done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (launch) begin
            boot_q <= 1'b0;
            hold_q <= 1'b1;
            st_q   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (t_zero) begin
            hold_q <= 1'b0;
            st_q   <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (t_zero || irq_low) begin
            idx_q     <= '0;
            mac_idx_q <= '0;
            st_q      <= ST_FETCH;
          end
        end
        ST_FETCH: st_q <= ST_ISSUE;
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (cpl) begin
            if (reg_rd) begin
              mac_we    <= 1'b1;
              mac_addr  <= mac_idx_q;
              mac_data  <= cpl_data;
              mac_idx_q <= mac_idx_q + 1'b1;
            end
            if (idx_q == SAW'(STEPS - 1)) begin
              seq_done <= 1'b1;
              st_q     <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ethrst_seq_chk.sv
module ethrst_seq_chk #(
  parameter int MAC_BYTES = 6,
  parameter int MAC_AW    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_go,
  input logic              reg_done,
  input logic              mac_we,
  input logic [MAC_AW-1:0] mac_addr,
  input logic              seq_done
);

  logic out_q;

  always_ff @(posedge clk) begin
    if (rst)           out_q <= 1'b0;
    else if (reg_done) out_q <= 1'b0;
    else if (reg_go)   out_q <= 1'b1;
  end

  // R6
  go_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_go |=> !reg_go);

  // R6
  go_wait_chk: assert property (@(posedge clk) disable iff (rst)
    reg_go |-> !out_q);

  // R8
  mac_after_reply_chk: assert property (@(posedge clk) disable iff (rst)
    mac_we |-> $past(reg_done));

  // R8
  mac_range_chk: assert property (@(posedge clk) disable iff (rst)
    mac_we |-> (mac_addr < MAC_AW'(MAC_BYTES)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

endmodule

bind ethrst_seq ethrst_seq_chk #(.MAC_BYTES(MAC_BYTES), .MAC_AW(MAC_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_go   (reg_go),
  .reg_done (reg_done),
  .mac_we   (mac_we),
  .mac_addr (mac_addr),
  .seq_done (seq_done)
);

// File: tb/ethrst_seq_tb.sv
module ethrst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 12;
  localparam int SETTLE     = 40;
  localparam int NMAC       = 6;
  localparam int NACC       = 4 + NMAC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dbg = 1'b0;
  logic irq_n = 1'b1;
  wire  nic_rst_n;
  logic reg_go, reg_rd, reg_done, mac_we, seq_done;
  logic [7:0] reg_addr, reg_wdata, mac_data;
  logic [7:0] reg_rdata = 8'h00;
  logic [3:0] mac_addr;
  logic rsp_done = 1'b0;
  logic inj_done = 1'b0;

  pullup (nic_rst_n);
  assign reg_done = rsp_done | inj_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  ethrst_seq #(.HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE), .MAC_BYTES(NMAC), .MAC_AW(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dbg_short(dbg),
    .nic_rst_n(nic_rst_n), .nic_irq_n(irq_n),
    .reg_go(reg_go), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_done(reg_done),
    .mac_we(mac_we), .mac_addr(mac_addr), .mac_data(mac_data), .seq_done(seq_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  // Transceiver model and port monitor
  int rsp_dly = 0;
  bit t_pend = 0;
  int t_wait = 0;
  bit go_prev = 0, done_prev = 0;
  int go_cnt = 0, mac_cnt = 0, done_cnt = 0;
  logic [7:0] lg_addr [16];
  logic [7:0] lg_wd   [16];
  logic       lg_rd   [16];
  logic [7:0] mac_mem [16];

  initial begin
    forever begin
      @(negedge clk);
      rsp_done = 1'b0;
      if (reg_go) begin
        if (go_prev) chk(0, "R6", "go wider than one clock", 2, 1);
        if (t_pend)  chk(0, "R6", "go while access outstanding", 1, 0);
        if (go_cnt < 16) begin
          lg_addr[go_cnt] = reg_addr;
          lg_wd[go_cnt]   = reg_wdata;
          lg_rd[go_cnt]   = reg_rd;
        end
        go_cnt++;
        reg_rdata = reg_addr ^ 8'hA5;
        if (rsp_dly == 0) rsp_done = 1'b1;
        else begin t_pend = 1; t_wait = rsp_dly; end
      end else if (t_pend) begin
        t_wait--;
        if (t_wait == 0) begin rsp_done = 1'b1; t_pend = 0; end
      end
      go_prev = reg_go;
      if (mac_we) begin
        if (mac_addr != 4'(mac_cnt)) chk(0, "R8", "MAC write order", mac_addr, mac_cnt);
        mac_mem[mac_addr] = mac_data;
        mac_cnt++;
      end
      if (seq_done) begin
        if (done_prev) chk(0, "R9", "done wider than one clock", 2, 1);
        done_cnt++;
      end
      done_prev = seq_done;
    end
  end

  task automatic clear_log();
    go_cnt = 0; mac_cnt = 0; done_cnt = 0;
    for (int i = 0; i < 16; i++) mac_mem[i] = 8'h00;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic measure(output int low, output int gap);
    low = 0;
    while (nic_rst_n === 1'b0 && low < 100000) begin low++; @(negedge clk); end
    gap = 0;
    while (!reg_go && gap < 100000) begin gap++; @(negedge clk); end
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 20000) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_addr(int i);
    case (i)
      0: return 8'h04; 1: return 8'h05; 2: return 8'h06; 3: return 8'h07;
      default: return 8'h60 + 8'(i - 4);
    endcase
  endfunction

  function automatic logic [7:0] exp_wd(int i);
    case (i)
      0: return 8'h80; 1: return 8'h10; 2: return 8'h3C; 3: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_run();
    chk(go_cnt == NACC, "R7", "access count", go_cnt, NACC);
    for (int i = 0; i < NACC && i < go_cnt; i++) begin
      chk(lg_addr[i] == exp_addr(i), "R7", "access address", lg_addr[i], exp_addr(i));
      chk(lg_rd[i] == (i >= 4), "R7", "read flag", lg_rd[i], (i >= 4));
      if (i < 4) chk(lg_wd[i] == exp_wd(i), "R7", "write data", lg_wd[i], exp_wd(i));
    end
    chk(mac_cnt == NMAC, "R8", "MAC write count", mac_cnt, NMAC);
    for (int i = 0; i < NMAC; i++)
      chk(mac_mem[i] == ((8'h60 + 8'(i)) ^ 8'hA5), "R8", "MAC byte", mac_mem[i], (8'h60 + i) ^ 8'hA5);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
  endtask

  task automatic t_reset_boot();
    int low, gap;
    rst = 1'b1; rsp_dly = 0;
    repeat (3) @(negedge clk);
    chk(nic_rst_n === 1'b1, "R1", "pin released in reset", nic_rst_n, 1);
    chk(!reg_go && !mac_we && !seq_done, "R1", "outputs idle in reset", reg_go | mac_we | seq_done, 0);
    clear_log();
    rst = 1'b0;
    @(negedge clk);
    measure(low, gap);
    chk(low == HOLD, "R3", "reset pin low length", low, HOLD);
    chk(gap == SETTLE + 2, "R4", "release to first go", gap, SETTLE + 2);
    wait_done();
    chk(go_cnt > 0, "R2", "run started after reset", go_cnt, NACC);
    check_run();
  endtask

  task automatic t_restart_irq();
    int low, gap;
    irq_n = 1'b0; rsp_dly = 1;
    clear_log();
    kick();
    measure(low, gap);
    chk(low == HOLD, "R3", "reset pin low length on restart", low, HOLD);
    chk(gap == 3, "R4", "interrupt cuts settle", gap, 3);
    wait_done();
    chk(go_cnt > 0, "R2", "start pulse begins run", go_cnt, NACC);
    check_run();
    irq_n = 1'b1;
  endtask

  task automatic t_debug();
    int low, gap;
    dbg = 1'b1; rsp_dly = 3;
    clear_log();
    kick();
    measure(low, gap);
    chk(low == 1, "R5", "debug reset low length", low, 1);
    chk(gap == 3, "R5", "debug settle gap", gap, 3);
    wait_done();
    check_run();
    dbg = 1'b0;
  endtask

  task automatic t_busy_start();
    int low_after = 0, n = 0;
    rsp_dly = 2;
    clear_log();
    kick();
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (go_cnt < 3 && n < 20000) begin n++; @(negedge clk); end
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    for (int i = 0; i < 60; i++) begin
      if (nic_rst_n === 1'b0) low_after++;
      @(negedge clk);
    end
    chk(go_cnt == NACC, "R10", "accesses with busy start", go_cnt, NACC);
    chk(done_cnt == 1, "R10", "done pulses with busy start", done_cnt, 1);
    chk(low_after == 0, "R10", "no new reset after run", low_after, 0);
  endtask

  task automatic t_stray_done();
    rsp_dly = 6;
    clear_log();
    @(negedge clk); inj_done = 1'b1;
    @(negedge clk); inj_done = 1'b0;
    repeat (5) @(negedge clk);
    chk(go_cnt == 0 && mac_cnt == 0, "R6", "stray done while idle", go_cnt + mac_cnt, 0);
    kick();
    repeat (4) @(negedge clk);
    inj_done = 1'b1;
    repeat (2) @(negedge clk);
    inj_done = 1'b0;
    wait_done();
    check_run();
  endtask

  initial begin
    t_reset_boot();
    t_restart_irq();
    t_debug();
    t_busy_start();
    t_stray_done();
    summary();
  end

endmodule